// File: doc/BRIEF.md
# Home-Node Zero-Write Sequencer

This block runs one dataless zero-write transaction at a time on behalf of a coherent home node. A requester asks for a snoopable line to become all zeros without sending any write data. The sequencer takes the line address, the requester's identifier, the line's current coherence state and the directory's sharer vector. Each cache that shares the line gets an invalidating snoop, and the block waits for one response per snoop. It then fills its line buffer with zeros, marks every byte valid and takes unique ownership. It acknowledges the requester in either a split style or a combined style. It finishes by asking for a fill check and then a tag write, and that tag write names the requester as owner and empties the sharer vector.

A busy sequencer accepts nothing, so a second request to the line in flight waits at the request handshake. The response style comes from a configuration input that is sampled when the request is accepted. On acceptance the block also classifies the request as a hit or a miss from the supplied line state.

Top module: `hn_zero_write_seq`

## Requirements
- R1: After reset `req_ready` is 1. `snp_valid`, `rsp_valid`, `fill_req`, `tag_wr` and `done` are 0. `line_bvalid` is all zeros, `line_data` is all zeros and `line_unique` is 0.
- R2: A request is accepted only on a cycle where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from the cycle after acceptance until the cycle after the tag write, so a request to the same line (or any line) offered meanwhile is not taken.
- R3: On the acceptance cycle `req_hit` is 1 if `req_state` is 2 to 7 (line present locally in some shared or unique, clean or dirty form). `req_miss` is 1 if `req_state` is 0 (invalid) or 1 (held only remotely). Both are 0 on every other cycle, and both classes run the same sequence.
- R4: For each bit set in the latched sharer vector, one snoop is offered on `snp_valid`, lowest bit index first, with `snp_tgt` equal to that index and `snp_addr` equal to the request address. A zero sharer vector produces no snoop.
- R5: `snpresp_ready` is 1 only while snoops issued for the current request still lack a response. Each response handshake settles exactly one snoop. A snoop issued and a response taken in the same cycle are both counted. `snpresp_valid` offered with nothing outstanding has no effect.
- R6: On acceptance the line buffer is poisoned: all data bits are 1, all byte-valid bits are 0 and `line_unique` is 0. The zero fill happens one cycle after the last snoop response (or, with no sharers, the cycle after acceptance). It sets all data to 0, all byte-valid bits to 1 and `line_unique` to 1, before any response is offered.
- R7: With `cfg_split`=1 at acceptance, the block sends a data-buffer-ID response (`rsp_kind`=0) and then a completion (`rsp_kind`=1). With `cfg_split`=0 it sends a single combined response (`rsp_kind`=2). `rsp_tgt` is the requester. Changes to `cfg_split` after acceptance have no effect.
- R8: The cycle after the final response handshake, `fill_req` pulses for one cycle with `fill_addr` equal to the request address. In the following cycle `tag_wr` and `done` pulse with `tag_addr` equal to the request address, `tag_owner` equal to the requester and `tag_sharers` all zeros.
- R9: An offered snoop or response holds its valid and its fields unchanged until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Zero-write request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_addr | input | ADDR_W | Line address |
| req_src | input | ID_W | Requester identifier |
| req_state | input | 3 | Line state: 0 invalid, 1 remote only, 2..7 locally present |
| req_sharers | input | NUM_SHARERS | Directory sharer vector |
| cfg_split | input | 1 | 1 = split responses, 0 = combined |
| req_hit | output | 1 | Accepted request found the line locally |
| req_miss | output | 1 | Accepted request missed locally |
| snp_valid | output | 1 | Invalidating snoop offered |
| snp_ready | input | 1 | Snoop taken |
| snp_addr | output | ADDR_W | Snoop line address |
| snp_tgt | output | SIDX_W | Sharer index being snooped |
| snpresp_valid | input | 1 | Snoop response offered |
| snpresp_ready | output | 1 | Snoop response can be taken |
| rsp_valid | output | 1 | Response to requester offered |
| rsp_ready | input | 1 | Response taken |
| rsp_kind | output | 2 | 0 buffer-ID, 1 completion, 2 combined |
| rsp_tgt | output | ID_W | Response destination |
| line_data | output | LINE_BYTES*8 | Line buffer contents |
| line_bvalid | output | LINE_BYTES | Per-byte valid bits |
| line_unique | output | 1 | Unique ownership held |
| fill_req | output | 1 | Cache fill check request pulse |
| fill_addr | output | ADDR_W | Fill check address |
| tag_wr | output | 1 | Tag array write pulse |
| tag_addr | output | ADDR_W | Tag write address |
| tag_owner | output | ID_W | Owner recorded by the tag write |
| tag_sharers | output | NUM_SHARERS | Sharer vector written (cleared) |
| done | output | 1 | Transaction finished |

## Verification
Snoop issue and snoop-response intake are the two functions that can land in the same cycle. The outstanding count must then stay unchanged rather than lose or gain one. The bench sets up this case by snooping several sharers while the responder raises `snpresp_valid` in the same cycles that snoops are still being offered. Its behavioural model tracks outstanding snoops in a plain integer and checks `snpresp_ready`, the end of the wait and the timing of the zero fill on every clock. A miscounted overlap shows up as a zero fill that comes early or late, or as a `snpresp_ready` that has the wrong value.

// File: rtl/hn_zero_write_seq.sv
module hn_zero_write_seq #(
  parameter int ADDR_W      = 32,
  parameter int ID_W        = 4,
  parameter int NUM_SHARERS = 4,
  parameter int LINE_BYTES  = 64,
  localparam int LINE_W = LINE_BYTES * 8,
  localparam int SIDX_W = (NUM_SHARERS > 1) ? $clog2(NUM_SHARERS) : 1,
  localparam int CNT_W  = $clog2(NUM_SHARERS + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [ID_W-1:0]        req_src,
  input  logic [2:0]             req_state,
  input  logic [NUM_SHARERS-1:0] req_sharers,
  input  logic                   cfg_split,
  output logic                   req_hit,
  output logic                   req_miss,
  output logic                   snp_valid,
  input  logic                   snp_ready,
  output logic [ADDR_W-1:0]      snp_addr,
  output logic [SIDX_W-1:0]      snp_tgt,
  input  logic                   snpresp_valid,
  output logic                   snpresp_ready,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic [1:0]             rsp_kind,
  output logic [ID_W-1:0]        rsp_tgt,
  output logic [LINE_W-1:0]      line_data,
  output logic [LINE_BYTES-1:0]  line_bvalid,
  output logic                   line_unique,
  output logic                   fill_req,
  output logic [ADDR_W-1:0]      fill_addr,
  output logic                   tag_wr,
  output logic [ADDR_W-1:0]      tag_addr,
  output logic [ID_W-1:0]        tag_owner,
  output logic [NUM_SHARERS-1:0] tag_sharers,
  output logic                   done
);

  localparam logic [1:0] RK_DBID     = 2'd0;
  localparam logic [1:0] RK_COMP     = 2'd1;
  localparam logic [1:0] RK_COMPDBID = 2'd2;

  typedef enum logic [2:0] {
    S_IDLE, S_SNOOP, S_WAIT, S_ZERO, S_RESP1, S_RESP2, S_FILL, S_TAG
  } state_t;

  state_t                 state;
  logic [ADDR_W-1:0]      addr_q;
  logic [ID_W-1:0]        src_q;
  logic                   split_q;
  logic [NUM_SHARERS-1:0] todo_q;
  logic [CNT_W-1:0]       pend_q;
  logic [SIDX_W-1:0]      low_idx;
  logic [NUM_SHARERS-1:0] todo_nxt;

  wire accept   = req_valid && req_ready;
  wire snp_fire = snp_valid && snp_ready;
  wire sr_fire  = snpresp_valid && snpresp_ready;
  wire rsp_fire = rsp_valid && rsp_ready;

  always_comb begin
    low_idx = '0;
    for (int i = NUM_SHARERS - 1; i >= 0; i--)
      if (todo_q[i]) low_idx = SIDX_W'(i);
  end

  assign todo_nxt = todo_q & ~(NUM_SHARERS'(1) << low_idx);

  assign req_ready     = (state == S_IDLE);
  assign req_hit       = accept && (req_state >= 3'd2);
  assign req_miss      = accept && (req_state <  3'd2);
  assign snp_valid     = (state == S_SNOOP);
  assign snp_addr      = addr_q;
  assign snp_tgt       = low_idx;
  assign snpresp_ready = ((state == S_SNOOP) || (state == S_WAIT)) && (pend_q != '0);
  assign rsp_valid     = (state == S_RESP1) || (state == S_RESP2);
  assign rsp_kind      = (state == S_RESP2) ? RK_COMP : (split_q ? RK_DBID : RK_COMPDBID);
  assign rsp_tgt       = src_q;
  assign fill_req      = (state == S_FILL);
  assign fill_addr     = addr_q;
  assign tag_wr        = (state == S_TAG);
  assign tag_addr      = addr_q;
  assign tag_owner     = src_q;
  assign tag_sharers   = '0;
  assign done          = tag_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      addr_q      <= '0;
      src_q       <= '0;
      split_q     <= 1'b0;
      todo_q      <= '0;
      pend_q      <= '0;
      line_data   <= '0;
      line_bvalid <= '0;
      line_unique <= 1'b0;
    end else begin
      pend_q <= pend_q + CNT_W'(snp_fire) - CNT_W'(sr_fire);
      unique case (state)
        S_IDLE: if (accept) begin
          addr_q      <= req_addr;
          src_q       <= req_src;
          split_q     <= cfg_split;
          todo_q      <= req_sharers;
          line_data   <= '1;
          line_bvalid <= '0;
          line_unique <= 1'b0;
          state       <= (req_sharers != '0) ? S_SNOOP : S_ZERO;
        end
        S_SNOOP: if (snp_fire) begin
          todo_q <= todo_nxt;
          if (todo_nxt == '0) state <= S_WAIT;
        end
        S_WAIT: if (pend_q == '0) state <= S_ZERO;
        S_ZERO: begin
          line_data   <= '0;
          line_bvalid <= '1;
          line_unique <= 1'b1;
          state       <= S_RESP1;
        end
        S_RESP1: if (rsp_fire) state <= split_q ? S_RESP2 : S_FILL;
        S_RESP2: if (rsp_fire) state <= S_FILL;
        S_FILL:  state <= S_TAG;
        S_TAG:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R6
  rsp_after_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (&line_bvalid && line_unique && line_data == '0));

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_kind) && $stable(rsp_tgt));

  // R9
  snp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && !snp_ready |=> snp_valid && $stable(snp_tgt) && $stable(snp_addr));

  // R8
  fill_then_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req |=> tag_wr && !fill_req);

  // R2
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  // R7
  comp_follows_dbid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fire && rsp_kind == RK_DBID |=> rsp_valid && rsp_kind == RK_COMP);

  // R5
  pend_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q <= CNT_W'(NUM_SHARERS));

  // R3
  hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_hit && req_miss));

endmodule

// File: tb/hn_zero_write_seq_test.sv
module hn_zero_write_seq_test;
  localparam int AW = 32, IW = 4, NS = 4, LB = 64;
  localparam int SW = 2;

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic req_valid = 0, cfg_split = 0, snp_ready = 0, snpresp_valid = 0, rsp_ready = 0;
  logic [AW-1:0] req_addr = 0;
  logic [IW-1:0] req_src = 0;
  logic [2:0] req_state = 0;
  logic [NS-1:0] req_sharers = 0;
  logic req_ready, req_hit, req_miss, snp_valid, snpresp_ready, rsp_valid;
  logic line_unique, fill_req, tag_wr, done;
  logic [AW-1:0] snp_addr, fill_addr, tag_addr;
  logic [SW-1:0] snp_tgt;
  logic [1:0] rsp_kind;
  logic [IW-1:0] rsp_tgt, tag_owner;
  logic [LB*8-1:0] line_data;
  logic [LB-1:0] line_bvalid;
  logic [NS-1:0] tag_sharers;

  hn_zero_write_seq #(.ADDR_W(AW), .ID_W(IW), .NUM_SHARERS(NS), .LINE_BYTES(LB)) uut (
    .clk, .rst_n, .req_valid, .req_ready, .req_addr, .req_src, .req_state,
    .req_sharers, .cfg_split, .req_hit, .req_miss, .snp_valid, .snp_ready,
    .snp_addr, .snp_tgt, .snpresp_valid, .snpresp_ready, .rsp_valid, .rsp_ready,
    .rsp_kind, .rsp_tgt, .line_data, .line_bvalid, .line_unique, .fill_req,
    .fill_addr, .tag_wr, .tag_addr, .tag_owner, .tag_sharers, .done);

  int tests = 0, fails = 0, cyc = 0, dones = 0;
  bit finished = 0;
  int rdy_mode = 0;

  // behavioural model: phase 0 idle,1 snooping,2 awaiting,3 zeroing,4 first rsp,5 second rsp,6 fill,7 tag
  int ph = 0;
  int tq[$];
  int outst = 0;
  bit m_split = 0, m_full = 0, m_uniq = 0, m_zero = 1, m_acc = 0;
  longint m_addr = 0, m_src = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; tq.delete(); outst = 0; m_full = 0; m_uniq = 0; m_zero = 1; m_acc = 0;
    end else begin
      bit snpf, srf, rspf;
      int old_out;
      old_out = outst;
      snpf = (ph == 1) && snp_ready;
      srf  = (ph == 1 || ph == 2) && old_out > 0 && snpresp_valid;
      rspf = (ph == 4 || ph == 5) && rsp_ready;
      m_acc = 0;
      case (ph)
        0: if (req_valid) begin
          m_acc = 1; m_addr = req_addr; m_src = req_src; m_split = cfg_split;
          tq.delete();
          for (int i = 0; i < NS; i++) if (req_sharers[i]) tq.push_back(i);
          m_full = 0; m_uniq = 0; m_zero = 0;
          ph = (tq.size() > 0) ? 1 : 3;
        end
        1: if (snpf) begin void'(tq.pop_front()); if (tq.size() == 0) ph = 2; end
        2: if (old_out == 0) ph = 3;
        3: begin m_full = 1; m_uniq = 1; m_zero = 1; ph = 4; end
        4: if (rspf) ph = m_split ? 5 : 6;
        5: if (rspf) ph = 6;
        6: ph = 7;
        7: begin ph = 0; dones++; end
        default: ph = 0;
      endcase
      outst = old_out + int'(snpf) - int'(srf);
    end
  end

  task automatic chk(input string rq, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d (cycle %0d)", rq, act, exp, cyc);
    end
  endtask

  always @(negedge clk) if (rst_n && !finished) begin
    longint dstate;
    bit exp_acc;
    exp_acc = (ph == 0) && req_valid;
    chk("R2 req_ready", req_ready, ph == 0);
    chk("R3 hit", req_hit, exp_acc && req_state >= 2);
    chk("R3 miss", req_miss, exp_acc && req_state < 2);
    chk("R4 snp_valid", snp_valid, ph == 1);
    if (ph == 1) begin
      chk("R4 snp_tgt", snp_tgt, tq[0]);
      chk("R4 snp_addr", snp_addr, m_addr);
    end
    chk("R5 snpresp_ready", snpresp_ready, (ph == 1 || ph == 2) && outst > 0);
    chk("R7 rsp_valid", rsp_valid, ph == 4 || ph == 5);
    if (ph == 4) chk("R7 rsp_kind first", rsp_kind, m_split ? 0 : 2);
    if (ph == 5) chk("R7 rsp_kind second", rsp_kind, 1);
    if (ph == 4 || ph == 5) chk("R7 rsp_tgt", rsp_tgt, m_src);
    chk("R8 fill_req", fill_req, ph == 6);
    if (ph == 6) chk("R8 fill_addr", fill_addr, m_addr);
    chk("R8 tag_wr", tag_wr, ph == 7);
    chk("R8 done", done, ph == 7);
    if (ph == 7) begin
      chk("R8 tag_addr", tag_addr, m_addr);
      chk("R8 tag_owner", tag_owner, m_src);
      chk("R8 tag_sharers", tag_sharers, 0);
    end
    dstate = (line_data == '0) ? 0 : ((&line_data) ? 1 : 2);
    chk("R6 line_data", dstate, m_zero ? 0 : 1);
    chk("R6 line_bvalid", line_bvalid, m_full ? {LB{1'b1}} : 0);
    chk("R6 line_unique", line_unique, m_uniq);
  end

  always @(negedge clk) begin
    #1;
    case (rdy_mode)
      0: begin snp_ready = 1; rsp_ready = 1; snpresp_valid = (outst > 0); end
      1: begin
        snp_ready = ($urandom_range(0, 3) != 0);
        rsp_ready = ($urandom_range(0, 2) != 0);
        snpresp_valid = ($urandom_range(0, 2) != 0);
      end
      default: begin
        snp_ready = ($urandom_range(0, 1) != 0);
        rsp_ready = ($urandom_range(0, 4) == 0);
        snpresp_valid = 1;
      end
    endcase
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog R2 act=busy exp=finished");
      summary();
    end
  end

  task automatic run_txn(input longint a, input int s, input int st, input int sh, input bit sp);
    @(negedge clk); #2;
    req_valid = 1; req_addr = AW'(a); req_src = IW'(s); req_state = 3'(st);
    req_sharers = NS'(sh); cfg_split = sp;
    do begin @(negedge clk); #2; end while (!m_acc);
    req_valid = 0;
    cfg_split = ~sp;  // R7: ignored after acceptance
  endtask

  task automatic wait_idle();
    do begin @(negedge clk); #2; end while (ph != 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk("R1 req_ready", req_ready, 1);
    chk("R1 snp_valid", snp_valid, 0);
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 tag_wr", tag_wr, 0);
    chk("R1 line_bvalid", line_bvalid, 0);
    chk("R1 line_unique", line_unique, 0);
    chk("R1 line_data", line_data == '0, 1);

    rdy_mode = 0;
    run_txn(64'h100, 3, 0, 0, 0); wait_idle();          // miss, no sharers, combined
    run_txn(64'h140, 5, 5, 4'b1010, 1); wait_idle();    // hit, two sharers, split
    rdy_mode = 2;
    run_txn(64'h180, 7, 1, 4'b1111, 0); wait_idle();    // R5 overlap of issue and response
    rdy_mode = 1;
    run_txn(64'h1c0, 2, 3, 4'b0001, 1);
    run_txn(64'h1c0, 9, 2, 4'b1000, 0);                 // R2 same line offered while busy
    wait_idle();
    for (int k = 0; k < 150; k++) begin
      rdy_mode = $urandom_range(0, 2);
      run_txn(longint'($urandom) & 64'hffff_ffc0, $urandom_range(0, 15),
              $urandom_range(0, 7), $urandom_range(0, 15), 1'($urandom_range(0, 1)));
    end
    wait_idle();
    repeat (3) @(negedge clk);
    chk("R8 done count", dones, 155);
    summary();
  end
endmodule